// File: doc/BRIEF.md
# Flash Programming Sequencer

This block sits on the host side of an asynchronous byte-wide flash bus. It drives the address lines, the data lines with their drive enable, and the active-low chip-enable, output-enable and write-enable strobes. On a single start request it programs one byte, erases one sector, or erases the whole chip.

Each operation goes out as a fixed series of unlock and command writes. Every write holds address and data steady across a write-enable pulse whose low and high widths are counted in system clocks. The block then polls the target address for completion. It does this either by comparing bit 7 with the value expected at the end, or by reading until bit 6 stops changing between two reads. A program ends with one read-back of the byte, and a mismatch is reported as an error together with done.

The host gives the operation, the poll method, the address and the data with a one-cycle start. It then waits for the one-cycle done pulse. Requests that arrive while an operation is running are dropped.

Top module: `flash_prog_seq`

## Requirements
- R1: With op_i = 2'b00 (program), exactly four writes are issued in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then addr_i/data_i.
- R2: With op_i = 2'b01 (sector erase), or with op_i = 2'b10 or 2'b11 (chip erase), exactly six writes are issued: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, and then addr_i/30h for a sector or 5555h/10h for the chip.
- R3: In every write cycle, chip enable is low and output enable is high while write enable is low. Write enable stays low for exactly WE_LO_CYC clocks. Address and data do not change while the data lines are driven.
- R4: fl_data_oe_o is high only inside write cycles, with chip enable low and output enable high. It is low during reads and while idle.
- R5: Every read holds chip enable and output enable low, with write enable high, for exactly RD_WAIT_CYC clocks.
- R6: With poll_mode_i = 0, the target address is read repeatedly until bit 7 equals the expected value: data_i[7] for a program, 1 for an erase.
- R7: With poll_mode_i = 1, the target address is read repeatedly until two successive reads return the same bit 6. At least two reads are always made.
- R8: After a program completes, one more read of the target address is made. error_o is high with done_o exactly when that byte differs from data_i. An erase never reports an error.
- R9: busy_o rises in the cycle after an accepted start and falls after the done cycle. done_o is high for exactly one cycle.
- R10: start_i is ignored while busy_o is high, including the done cycle. It changes neither the current operation nor the bus.
- R11: During and right after reset, all three strobes are high, the data lines are released, and busy_o, done_o and error_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| poll_mode_i | input | 1 | 0 polls bit 7, 1 polls bit 6 toggle |
| addr_i | input | AW | Target byte or sector address |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Verify mismatch, valid with done_o |
| fl_addr_o | output | AW | Flash address lines |
| fl_data_o | output | 8 | Flash write data |
| fl_data_oe_o | output | 1 | Drive enable for the flash data lines |
| fl_data_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_we_no | output | 1 | Write enable, active low |

## Verification
Two functions can meet in one cycle: the completion pulse and a fresh start request. The bench provokes this by raising start_i exactly in the cycle where done_o is seen. It then watches the bus for many cycles and expects chip enable to stay high and busy_o to stay low. A second collision comes from a start pulse in the middle of a write cycle. It is judged by the write log matching the first operation's script alone. A behavioural flash model in the bench answers the reads. It gives a chosen number of busy reads with bit 7 inverted and bit 6 toggling, so the exact poll-read count can be predicted for both methods.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10
  } flash_op_e;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_WSET,
    BS_WLOW,
    BS_WHIGH,
    BS_RD
  } bus_st_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_POLL,
    PH_VERIFY
  } seq_ph_e;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_NOP   = 8'hFF;

  localparam int STEP_W     = 3;
  localparam int PROG_STEPS = 4;
  localparam int ERASE_STEPS = 6;

endpackage

// File: rtl/flash_cmd_script.sv
module flash_cmd_script
  import flash_seq_pkg::*;
#(
  parameter int             AW     = 16,
  parameter logic [AW-1:0]  UNLK_A = AW'('h5555),
  parameter logic [AW-1:0]  UNLK_B = AW'('h2AAA)
) (
  input  logic [1:0]        op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  output logic [AW-1:0]     addr_o,
  output logic [7:0]        data_o,
  output logic              last_o
);

  localparam logic [STEP_W-1:0] PROG_LAST  = STEP_W'(PROG_STEPS - 1);
  localparam logic [STEP_W-1:0] ERASE_LAST = STEP_W'(ERASE_STEPS - 1);

  logic is_prog, is_chip;

  assign is_prog = (op_i == OP_PROG);
  assign is_chip = op_i[1];

  always_comb begin
    addr_o = UNLK_A;
    data_o = CMD_NOP;
    unique case (step_i)
      3'd0: begin addr_o = UNLK_A; data_o = CMD_KEY1; end
      3'd1: begin addr_o = UNLK_B; data_o = CMD_KEY2; end
      3'd2: begin addr_o = UNLK_A; data_o = is_prog ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        addr_o = is_prog ? tgt_addr_i : UNLK_A;
        data_o = is_prog ? tgt_data_i : CMD_KEY1;
      end
      3'd4: begin addr_o = UNLK_B; data_o = CMD_KEY2; end
      3'd5: begin
        addr_o = is_chip ? UNLK_A : tgt_addr_i;
        data_o = is_chip ? CMD_CHIP : CMD_SECT;
      end
      default: begin addr_o = UNLK_A; data_o = CMD_NOP; end
    endcase
  end

  assign last_o = is_prog ? (step_i == PROG_LAST) : (step_i == ERASE_LAST);

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int WE_LO_CYC   = 4,
  parameter int WE_HI_CYC   = 3,
  parameter int RD_WAIT_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          ack_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_data_o,
  output logic          fl_data_oe_o,
  input  logic [7:0]    fl_data_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);

  localparam int MAX_LH = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
  localparam int MAX_C  = (MAX_LH > RD_WAIT_CYC) ? MAX_LH : RD_WAIT_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LO_END = CW'(WE_LO_CYC - 1);
  localparam logic [CW-1:0] HI_END = CW'(WE_HI_CYC - 1);
  localparam logic [CW-1:0] RD_END = CW'(RD_WAIT_CYC - 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdat_q;
  logic [7:0]    rdat_q;
  logic          ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BS_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        BS_IDLE: if (req_i) begin
          addr_q <= addr_i;
          wdat_q <= wdata_i;
          cnt_q  <= '0;
          st_q   <= wr_i ? BS_WSET : BS_RD;
        end
        BS_WSET: st_q <= BS_WLOW;
        BS_WLOW: begin
          if (cnt_q == LO_END) begin
            cnt_q <= '0;
            st_q  <= BS_WHIGH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        BS_WHIGH: begin
          if (cnt_q == HI_END) begin
            cnt_q <= '0;
            st_q  <= BS_IDLE;
            ack_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        BS_RD: begin
          if (cnt_q == RD_END) begin
            rdat_q <= fl_data_i;
            cnt_q  <= '0;
            st_q   <= BS_IDLE;
            ack_q  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  // data stays driven one phase past the WE rise so the captured byte is held
  assign fl_ce_no     = (st_q == BS_IDLE);
  assign fl_we_no     = (st_q != BS_WLOW);
  assign fl_oe_no     = (st_q != BS_RD);
  assign fl_data_oe_o = (st_q == BS_WSET) || (st_q == BS_WLOW) || (st_q == BS_WHIGH);
  assign fl_addr_o    = addr_q;
  assign fl_data_o    = wdat_q;
  assign ack_o        = ack_q;
  assign rdata_o      = rdat_q;

  logic [CW:0] lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_run_q <= '0;
    else if (!fl_we_no) lo_run_q <= lo_run_q + 1'b1;
    else lo_run_q <= '0;
  end

  p_oe_high_on_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (fl_oe_no && !fl_ce_no));

  p_we_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (lo_run_q == (CW+1)'(WE_LO_CYC)));

  p_write_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_data_oe_o && $past(fl_data_oe_o)) |-> ($stable(fl_addr_o) && $stable(fl_data_o)));

  p_no_drive_on_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_data_oe_o |-> (fl_oe_no && !fl_ce_no));

  p_read_we_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> (fl_we_no && !fl_ce_no && !fl_data_oe_o));

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge (
  input  logic mode_i,
  input  logic exp7_i,
  input  logic rd7_i,
  input  logic rd6_i,
  input  logic have_prev_i,
  input  logic prev6_i,
  output logic complete_o
);

  always_comb begin
    if (mode_i) complete_o = have_prev_i && (rd6_i == prev6_i);
    else        complete_o = (rd7_i == exp7_i);
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            WE_LO_CYC   = 4,
  parameter int            WE_HI_CYC   = 3,
  parameter int            RD_WAIT_CYC = 3,
  parameter logic [AW-1:0] UNLK_A      = AW'('h5555),
  parameter logic [AW-1:0] UNLK_B      = AW'('h2AAA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          poll_mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_data_o,
  output logic          fl_data_oe_o,
  input  logic [7:0]    fl_data_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);

  seq_st_e           st_q;
  seq_ph_e           ph_q;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        op_q;
  logic              mode_q;
  logic [AW-1:0]     addr_q;
  logic [7:0]        data_q;
  logic              have_prev_q;
  logic              prev6_q;
  logic              err_q;

  logic [AW-1:0] scr_addr;
  logic [7:0]    scr_data;
  logic          scr_last;
  logic          bus_req, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_rdata;
  logic          is_prog, exp7, poll_done;

  assign is_prog = (op_q == OP_PROG);
  assign exp7    = is_prog ? data_q[7] : 1'b1;

  flash_cmd_script #(
    .AW(AW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)
  ) u_script (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (scr_addr),
    .data_o     (scr_data),
    .last_o     (scr_last)
  );

  flash_poll_judge u_judge (
    .mode_i      (mode_q),
    .exp7_i      (exp7),
    .rd7_i       (bus_rdata[7]),
    .rd6_i       (bus_rdata[6]),
    .have_prev_i (have_prev_q),
    .prev6_i     (prev6_q),
    .complete_o  (poll_done)
  );

  assign bus_req  = (st_q == SQ_ISSUE);
  assign bus_wr   = (ph_q == PH_CMD);
  assign bus_addr = (ph_q == PH_CMD) ? scr_addr : addr_q;

  flash_bus_cycle #(
    .AW(AW), .WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC), .RD_WAIT_CYC(RD_WAIT_CYC)
  ) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (bus_req),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (scr_data),
    .ack_o        (bus_ack),
    .rdata_o      (bus_rdata),
    .fl_addr_o    (fl_addr_o),
    .fl_data_o    (fl_data_o),
    .fl_data_oe_o (fl_data_oe_o),
    .fl_data_i    (fl_data_i),
    .fl_ce_no     (fl_ce_no),
    .fl_oe_no     (fl_oe_no),
    .fl_we_no     (fl_we_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      ph_q        <= PH_CMD;
      step_q      <= '0;
      op_q        <= '0;
      mode_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          op_q        <= op_i;
          mode_q      <= poll_mode_i;
          addr_q      <= addr_i;
          data_q      <= data_i;
          step_q      <= '0;
          ph_q        <= PH_CMD;
          have_prev_q <= 1'b0;
          err_q       <= 1'b0;
          st_q        <= SQ_ISSUE;
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        SQ_WAIT: if (bus_ack) begin
          st_q <= SQ_ISSUE;
          unique case (ph_q)
            PH_CMD: begin
              if (scr_last) begin
                ph_q        <= PH_POLL;
                have_prev_q <= 1'b0;
              end else step_q <= step_q + 1'b1;
            end
            PH_POLL: begin
              if (poll_done) begin
                if (is_prog) ph_q <= PH_VERIFY;
                else         st_q <= SQ_DONE;
              end else begin
                prev6_q     <= bus_rdata[6];
                have_prev_q <= 1'b1;
              end
            end
            PH_VERIFY: begin
              err_q <= (bus_rdata != data_q);
              st_q  <= SQ_DONE;
            end
            default: st_q <= SQ_DONE;
          endcase
        end
        SQ_DONE: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_DONE);
  assign error_o = done_o && err_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_error_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

  p_idle_bus_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_ce_no && fl_we_no && fl_oe_no && !fl_data_oe_o));

  p_dpoll_retry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_WAIT && bus_ack && ph_q == PH_POLL && !mode_q && bus_rdata[7] != exp7)
      |=> (st_q == SQ_ISSUE && ph_q == PH_POLL));

  p_toggle_two_reads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_WAIT && bus_ack && ph_q == PH_POLL && mode_q && !have_prev_q)
      |=> (st_q == SQ_ISSUE && ph_q == PH_POLL));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  localparam int AW  = 16;
  localparam int WLO = 4;
  localparam int WHI = 3;
  localparam int RDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          busy_o, done_o, error_o;
  logic [AW-1:0] fl_addr_o;
  logic [7:0]    fl_data_o;
  logic          fl_data_oe_o;
  logic [7:0]    rd_val = 8'hFF;
  logic          fl_ce_no, fl_oe_no, fl_we_no;

  flash_prog_seq #(.AW(AW), .WE_LO_CYC(WLO), .WE_HI_CYC(WHI), .RD_WAIT_CYC(RDW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .poll_mode_i(mode_i),
    .addr_i(addr_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .fl_addr_o(fl_addr_o), .fl_data_o(fl_data_o), .fl_data_oe_o(fl_data_oe_o),
    .fl_data_i(rd_val), .fl_ce_no(fl_ce_no), .fl_oe_no(fl_oe_no), .fl_we_no(fl_we_no)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit timed_out = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) timed_out = 1'b1;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash model
  logic [7:0]    mem [0:1023];
  logic [AW-1:0] log_a [0:7];
  logic [7:0]    log_d [0:7];
  int nlog, nread, busy_left, busy_set, pend;
  bit tog;
  logic [AW-1:0] pend_a;
  logic [7:0]    pend_d;
  int proto_bad, drive_bad, width_bad, rd_bad, lo_cnt, rd_cnt;
  logic [AW-1:0] prev_a;
  logic [7:0]    prev_d;
  logic          prev_doe = 1'b0;

  always @(posedge fl_we_no) begin
    if (rst_n && !fl_ce_no) begin
      if (fl_oe_no !== 1'b1 || fl_data_oe_o !== 1'b1) proto_bad++;
      if (nlog < 8) begin
        log_a[nlog] = fl_addr_o;
        log_d[nlog] = fl_data_o;
      end
      nlog++;
      if (nlog == 4 && log_d[2] == 8'hA0) begin
        pend = 1; pend_a = fl_addr_o; pend_d = fl_data_o; busy_left = busy_set;
      end
      if (nlog == 6 && fl_data_o == 8'h30) begin
        pend = 2; pend_a = fl_addr_o; busy_left = busy_set;
      end
      if (nlog == 6 && fl_data_o == 8'h10) begin
        pend = 3; busy_left = busy_set;
      end
    end
  end

  always @(negedge fl_oe_no) begin
    if (rst_n) begin
      nread++;
      if (busy_left > 0) begin
        busy_left--;
        tog = ~tog;
        rd_val = {(pend == 1) ? ~pend_d[7] : 1'b0, tog, 6'h2A};
      end else begin
        if (pend == 1) mem[pend_a[9:0]] = mem[pend_a[9:0]] & pend_d;
        if (pend == 2) for (int i = 0; i < 1024; i++) if (i[9] == pend_a[9]) mem[i] = 8'hFF;
        if (pend == 3) for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        pend = 0;
        rd_val = mem[fl_addr_o[9:0]];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_no) lo_cnt++;
      else if (lo_cnt != 0) begin
        if (lo_cnt != WLO) width_bad++;
        lo_cnt = 0;
      end
      if (!fl_oe_no) rd_cnt++;
      else if (rd_cnt != 0) begin
        if (rd_cnt != RDW) rd_bad++;
        rd_cnt = 0;
      end
      if (!fl_oe_no && (fl_ce_no || !fl_we_no)) rd_bad++;
      if (fl_data_oe_o && (fl_ce_no || !fl_oe_no)) drive_bad++;
      if (!fl_we_no && (fl_ce_no || !fl_oe_no || !fl_data_oe_o)) proto_bad++;
      if (fl_data_oe_o && prev_doe && (fl_addr_o != prev_a || fl_data_o != prev_d)) proto_bad++;
      prev_doe = fl_data_oe_o;
      prev_a   = fl_addr_o;
      prev_d   = fl_data_o;
    end
  end

  function automatic logic [AW+7:0] exp_step(int op, int i, logic [AW-1:0] a, logic [7:0] d);
    case (i)
      0: return {16'h5555, 8'hAA};
      1: return {16'h2AAA, 8'h55};
      2: return {16'h5555, (op == 0) ? 8'hA0 : 8'h80};
      3: return (op == 0) ? {a, d} : {16'h5555, 8'hAA};
      4: return {16'h2AAA, 8'h55};
      default: return (op >= 2) ? {16'h5555, 8'h10} : {a, 8'h30};
    endcase
  endfunction

  function automatic int exp_reads(bit mode, int b, bit v6, bit prog);
    int r;
    if (!mode) r = b + 1;
    else if (b == 0) r = 2;
    else r = ((b % 2 == 1) == v6) ? b + 1 : b + 2;
    return r + (prog ? 1 : 0);
  endfunction

  task automatic run_op(int op, bit mode, logic [AW-1:0] a, logic [7:0] d, int b,
                        bit poke, bit late);
    logic [7:0] res;
    bit prog, exp_err, v6, ok;
    int nexp, ce_low, busy_seen;
    prog    = (op == 0);
    res     = mem[a[9:0]] & d;
    exp_err = prog && (res != d);
    v6      = prog ? res[6] : 1'b1;
    nexp    = prog ? 4 : 6;
    nlog = 0; nread = 0; busy_set = b; busy_left = 0; pend = 0; tog = 1'b0;
    proto_bad = 0; drive_bad = 0; width_bad = 0; rd_bad = 0;
    @(negedge clk);
    op_i = op[1:0]; mode_i = mode; addr_i = a; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R9 busy after start", busy_o, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      op_i = 2'b10; addr_i = 16'h03FF; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && !timed_out) @(negedge clk);
    if (timed_out) return;
    chk(error_o === exp_err, "R8 verify error flag", error_o, exp_err);
    ok = (nlog == nexp);
    for (int i = 0; i < nexp && i < 8; i++)
      if ({log_a[i], log_d[i]} != exp_step(op, i, a, d)) ok = 1'b0;
    if (poke) chk(ok, "R10 start while busy ignored", nlog, nexp);
    else if (prog) chk(ok, "R1 program script", nlog, nexp);
    else chk(ok, "R2 erase script", nlog, nexp);
    if (mode) chk(nread == exp_reads(mode, b, v6, prog), "R7 toggle poll reads", nread, exp_reads(mode, b, v6, prog));
    else chk(nread == exp_reads(mode, b, v6, prog), "R6 data poll reads", nread, exp_reads(mode, b, v6, prog));
    chk(proto_bad == 0 && width_bad == 0, "R3 write cycle timing", proto_bad + width_bad, 0);
    chk(drive_bad == 0, "R4 data drive window", drive_bad, 0);
    chk(rd_bad == 0, "R5 read cycle timing", rd_bad, 0);
    if (late) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b0 && busy_o === 1'b0, "R9 single done cycle", {done_o, busy_o}, 0);
    if (late) begin
      ce_low = 0; busy_seen = 0;
      repeat (15) begin
        @(negedge clk);
        if (!fl_ce_no) ce_low++;
        if (busy_o) busy_seen++;
      end
      chk(ce_low == 0 && busy_seen == 0, "R10 start in done cycle ignored", ce_low + busy_seen, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(fl_ce_no === 1 && fl_oe_no === 1 && fl_we_no === 1 && fl_data_oe_o === 0,
        "R11 bus idle in reset", {fl_ce_no, fl_oe_no, fl_we_no, fl_data_oe_o}, 4'he);
    chk(busy_o === 0 && done_o === 0 && error_o === 0, "R11 status in reset",
        {busy_o, done_o, error_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(fl_ce_no === 1 && fl_data_oe_o === 0 && busy_o === 0, "R11 idle after reset",
        {fl_ce_no, fl_data_oe_o, busy_o}, 3'b100);

    run_op(0, 1'b0, 16'h0005, 8'h5A, 3, 1'b0, 1'b0);
    run_op(0, 1'b0, 16'h0005, 8'h4A, 0, 1'b0, 1'b0);
    run_op(0, 1'b0, 16'h0020, 8'hF0, 2, 1'b0, 1'b0);
    run_op(0, 1'b0, 16'h0020, 8'h8F, 1, 1'b0, 1'b0);   // AND result 80h: mismatch
    run_op(1, 1'b1, 16'h0200, 8'h00, 4, 1'b0, 1'b0);
    run_op(0, 1'b1, 16'h0210, 8'h3C, 0, 1'b0, 1'b0);
    run_op(0, 1'b1, 16'h0300, 8'hC3, 5, 1'b1, 1'b0);
    run_op(2, 1'b0, 16'h0111, 8'h00, 2, 1'b0, 1'b1);
    run_op(3, 1'b1, 16'h0044, 8'h00, 1, 1'b0, 1'b0);

    for (int k = 0; k < 30 && !timed_out; k++) begin
      int op, b;
      bit mode;
      logic [AW-1:0] a;
      logic [7:0] d, r;
      op   = $urandom % 6;
      if (op > 3) op = 0;
      a    = AW'($urandom % 1024);
      d    = 8'($urandom);
      b    = $urandom % 6;
      mode = 1'($urandom);
      r    = mem[a[9:0]] & d;
      if (op == 0 && !mode && r[7] != d[7]) mode = 1'b1;
      run_op(op, mode, a, d, b, 1'b0, 1'b0);
    end

    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule